// File: doc/BRIEF.md
# Host Bus Front End with Pipelined Reads

This block sits between an 8-bit asynchronous host bus and the internal display memory and command path of a display controller. It accepts one of two host bus styles. The first uses one enable strobe together with a read/write level. The second uses separate active-low read and write strobes. The level on the host's reset pin picks the style. The pins are brought into the system clock domain. When a host access ends, the block emits a single-cycle operation pulse. The pulse carries a decoded operation kind and the byte the host presented.

A bus-holder register decouples host timing from memory timing. On a display-data read, the host receives the byte already in the holder. The memory word at the current address is then loaded into the holder. The first read after an address change or a write therefore returns stale data, and software issues one dummy read first. On a display-data write, the byte goes into the holder and is committed to memory with a one-cycle write strobe. Status reads drive the status byte supplied by the command logic. Command writes only forward the byte. Address counting and command meaning belong to the next block.

Top module: `hbi_host_port`

## Requirements
- R1: When `bus_rst_pin` is high, the enable style is active. An access lasts while `strb_a` (enable) is high, and `strb_b` high means read. When `bus_rst_pin` is low, the separate-strobe style is active. `strb_a` low is a read access and `strb_b` low is a write access.
- R2: Each completed access with `cs_n` low produces exactly one single-cycle `op_valid` pulse after the strobe ends. `op_kind` is encoded as 00 for data read (`dsel`=1, read), 01 for data write (`dsel`=1, write), 10 for status read (`dsel`=0, read) and 11 for command write (`dsel`=0, write). `op_data` carries the byte the host drove.
- R3: During a data read, `d_out` shows the holder content. When the read ends, the holder loads `ram_rdata`, so a read returns the word fetched by the preceding data read.
- R4: A data write puts the host byte on `ram_wdata` with a single-cycle `ram_we` pulse together with the operation pulse. The same byte becomes the holder content.
- R5: A status read drives `status_in` on `d_out`. Status reads and command writes leave the holder unchanged and raise no `ram_we`.
- R6: While `cs_n` is high, strobes produce no operation and no `ram_we`, and `d_oe` stays low.
- R7: `d_oe` is high only while a read access is in progress. It is never high while a write strobe is active.
- R8: Any edge on `bus_rst_pin` gives one single-cycle `bus_reset` pulse and clears the holder to zero, even while `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_rst_pin | input | 1 | Host reset pin; its level picks the bus style, and its edges reset |
| cs_n | input | 1 | Active-low chip select |
| dsel | input | 1 | 1 = display data, 0 = command or status |
| strb_a | input | 1 | Enable (enable style) or read strobe, active low (separate style) |
| strb_b | input | 1 | Read/write level (enable style) or write strobe, active low (separate style) |
| d_in | input | 8 | Host data bus, input side |
| d_out | output | 8 | Host data bus, output side |
| d_oe | output | 1 | Host data bus output enable |
| status_in | input | 8 | Status byte from command logic |
| ram_rdata | input | 8 | Memory word at the current address |
| ram_wdata | output | 8 | Write byte to memory |
| ram_we | output | 1 | Single-cycle memory write strobe |
| op_valid | output | 1 | Single-cycle operation pulse |
| op_kind | output | 2 | Operation kind, encoded as in R2 |
| op_data | output | 8 | Host byte of the operation |
| bus_reset | output | 1 | Single-cycle pulse on each edge of the host reset pin |

## Verification
Every cycle, the assertions check the following. Each operation pulse lasts one cycle. Nothing is decoded or driven while chip select is inactive. The output enable is low when a write operation completes. The holder takes the memory word after a data read, the host byte after a write, and zero after a reset edge. The stale-read pipelining is shown only by the bench scenarios. These scenarios sweep both bus styles and all four operation kinds with varying bytes. They also show the dummy-read ordering across writes, status reads and command writes, and the holder clear after a style switch.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  // Operation kind: bit1 = command side (dsel low), bit0 = write
  typedef enum logic [1:0] {
    OP_DRD = 2'b00,
    OP_DWR = 2'b01,
    OP_SRD = 2'b10,
    OP_CWR = 2'b11
  } hbi_op_e;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,          // must be at least 2
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_nx;

  always_comb begin
    stage_nx = {stage_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= stage_nx;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hbi_decode.sv
module hbi_decode import hbi_pkg::*; #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode,      // 1 = enable style, 0 = separate strobes
  input  logic          cs_n_s,
  input  logic          a_s,
  input  logic          b_s,
  input  logic          sel_s,
  input  logic [DW-1:0] d_s,
  output logic          op_valid,
  output hbi_op_e       op_kind,
  output logic [DW-1:0] op_data,
  output logic          rd_active
);
  logic          acc, rd;
  logic          acc_q, rd_q, sel_q;
  logic          rd_nx, sel_nx;
  logic [DW-1:0] dat_q, dat_nx;

  // Access decode per bus style
  always_comb begin
    if (mode) begin
      acc = ~cs_n_s & a_s;
      rd  = b_s;
    end else begin
      acc = ~cs_n_s & (~a_s | ~b_s);
      rd  = ~a_s;
    end
  end

  // Capture attributes while the access is open
  always_comb begin
    rd_nx  = rd_q;
    sel_nx = sel_q;
    dat_nx = dat_q;
    if (acc) begin
      rd_nx  = rd;
      sel_nx = sel_s;
      dat_nx = d_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      rd_q  <= 1'b0;
      sel_q <= 1'b0;
      dat_q <= '0;
    end else begin
      acc_q <= acc;
      rd_q  <= rd_nx;
      sel_q <= sel_nx;
      dat_q <= dat_nx;
    end
  end

  assign op_valid  = acc_q & ~acc;
  assign op_kind   = hbi_op_e'({~sel_q, ~rd_q});
  assign op_data   = dat_q;
  assign rd_active = acc & rd;

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  assert_cs_idle_no_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n_s && $past(cs_n_s)) |-> !op_valid);

  assert_enable_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && !a_s) |-> !rd_active);
endmodule

// File: rtl/hbi_holder.sv
module hbi_holder import hbi_pkg::*; #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          op_valid,
  input  hbi_op_e       op_kind,
  input  logic [DW-1:0] op_data,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] holder,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we
);
  logic [DW-1:0] hold_q, hold_nx;

  always_comb begin
    hold_nx = hold_q;
    if (clear)                               hold_nx = '0;
    else if (op_valid && op_kind == OP_DRD)  hold_nx = ram_rdata;
    else if (op_valid && op_kind == OP_DWR)  hold_nx = op_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_nx;
  end

  assign holder    = hold_q;
  assign ram_we    = op_valid && (op_kind == OP_DWR);
  assign ram_wdata = op_data;

  assert_read_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == OP_DRD && !clear) |=> holder == $past(ram_rdata));

  assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !clear) |=> holder == $past(ram_wdata));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> holder == '0);
endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port import hbi_pkg::*; #(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rst_pin,
  input  logic          cs_n,
  input  logic          dsel,
  input  logic          strb_a,
  input  logic          strb_b,
  input  logic [DW-1:0] d_in,
  output logic [DW-1:0] d_out,
  output logic          d_oe,
  input  logic [DW-1:0] status_in,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  output logic          op_valid,
  output logic [1:0]    op_kind,
  output logic [DW-1:0] op_data,
  output logic          bus_reset
);
  localparam int unsigned PW = DW + 5;
  // chip select resets to inactive so no access is seen before pins settle
  localparam logic [PW-1:0] PIN_RST = {2'b01, 3'b000, {DW{1'b0}}};

  // Reset: asserted asynchronously, released synchronously
  logic [1:0] rst_pipe;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  // Pin synchronization, all pins through the same depth
  logic [PW-1:0] pin_raw, pin_s;
  assign pin_raw = {bus_rst_pin, cs_n, dsel, strb_a, strb_b, d_in};

  hbi_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(srst_n), .d(pin_raw), .q(pin_s));

  logic          rpin_s, cs_s, sel_s, a_s, b_s;
  logic [DW-1:0] dat_s;
  assign rpin_s = pin_s[PW-1];
  assign cs_s   = pin_s[PW-2];
  assign sel_s  = pin_s[PW-3];
  assign a_s    = pin_s[PW-4];
  assign b_s    = pin_s[PW-5];
  assign dat_s  = pin_s[DW-1:0];

  // Host reset pin edge detect
  logic rpin_q;
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) rpin_q <= 1'b0;
    else         rpin_q <= rpin_s;
  end
  assign bus_reset = rpin_s ^ rpin_q;

  hbi_op_e       kind_e;
  logic          rd_active;
  logic [DW-1:0] holder;

  hbi_decode #(.DW(DW)) u_dec (
    .clk(clk), .rst_n(srst_n), .mode(rpin_s), .cs_n_s(cs_s),
    .a_s(a_s), .b_s(b_s), .sel_s(sel_s), .d_s(dat_s),
    .op_valid(op_valid), .op_kind(kind_e), .op_data(op_data),
    .rd_active(rd_active));

  hbi_holder #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(srst_n), .clear(bus_reset),
    .op_valid(op_valid), .op_kind(kind_e), .op_data(op_data),
    .ram_rdata(ram_rdata), .holder(holder),
    .ram_wdata(ram_wdata), .ram_we(ram_we));

  assign op_kind = kind_e;

  // Registered output side of the data bus
  logic          oe_q;
  logic [DW-1:0] dout_q, dout_nx;

  always_comb begin
    dout_nx = dout_q;
    if (rd_active) dout_nx = sel_s ? holder : status_in;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      oe_q   <= rd_active;
      dout_q <= dout_nx;
    end
  end

  assign d_oe  = oe_q;
  assign d_out = dout_q;

  assert_no_drive_on_write_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (op_valid && kind_e[0]) |-> !d_oe);

  assert_cs_no_drive_R6: assert property (@(posedge clk) disable iff (!srst_n)
    cs_s |=> !d_oe);
endmodule

// File: tb/hbi_host_port_test.sv
module hbi_host_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst_pin = 1'b0;
  logic       cs_n = 1'b0;
  logic       dsel = 1'b0;
  logic       strb_a = 1'b1;
  logic       strb_b = 1'b1;
  logic [7:0] d_in = '0;
  logic [7:0] d_out;
  logic       d_oe;
  logic [7:0] status_in = '0;
  logic [7:0] ram_rdata = '0;
  logic [7:0] ram_wdata;
  logic       ram_we;
  logic       op_valid;
  logic [1:0] op_kind;
  logic [7:0] op_data;
  logic       bus_reset;

  always #2 clk = ~clk;

  hbi_host_port uut (
    .clk(clk), .rst_n(rst_n), .bus_rst_pin(bus_rst_pin), .cs_n(cs_n),
    .dsel(dsel), .strb_a(strb_a), .strb_b(strb_b), .d_in(d_in),
    .d_out(d_out), .d_oe(d_oe), .status_in(status_in),
    .ram_rdata(ram_rdata), .ram_wdata(ram_wdata), .ram_we(ram_we),
    .op_valid(op_valid), .op_kind(op_kind), .op_data(op_data),
    .bus_reset(bus_reset));

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int op_cnt = 0, we_cnt = 0, brst_cnt = 0;
  logic [1:0] last_kind = '0;
  logic [7:0] last_data = '0, last_wd = '0;
  bit wr_active = 0;
  bit oe_wr_flag = 0;

  always @(negedge clk) begin
    if (op_valid === 1'b1) begin op_cnt++; last_kind = op_kind; last_data = op_data; end
    if (ram_we === 1'b1) begin we_cnt++; last_wd = ram_wdata; end
    if (bus_reset === 1'b1) brst_cnt++;
    if (d_oe === 1'b1 && wr_active) oe_wr_flag = 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One host access in the given style; samples the bus mid-access
  task automatic acc(input logic style, input logic sel, input logic rd,
                     input logic [7:0] wd, output logic [7:0] seen_d,
                     output logic seen_oe);
    @(negedge clk);
    dsel = sel; d_in = wd;
    if (style) begin strb_b = rd; @(negedge clk); strb_a = 1'b1; end
    else if (rd) strb_a = 1'b0;
    else         strb_b = 1'b0;
    wr_active = !rd;
    repeat (6) @(negedge clk);
    seen_d = d_out; seen_oe = d_oe;
    if (style) strb_a = 1'b0;
    else begin strb_a = 1'b1; strb_b = 1'b1; end
    repeat (6) @(negedge clk);
    wr_active = 0;
    if (style) strb_b = 1'b1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog all-reqs actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0] hm, sd;
    logic so;
    int n0, w0, b0;
    hm = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    // reset state
    chk("R6 reset oe", d_oe, 0);
    chk("R2 reset ops", op_cnt, 0);
    chk("R4 reset we", we_cnt, 0);
    chk("R8 reset pulses", brst_cnt, 0);

    for (int s = 0; s < 2; s++) begin
      if (s == 1) begin
        // switch to enable style with chip deselected: reset edge still acts
        b0 = brst_cnt;
        cs_n = 1'b1; strb_a = 1'b0; strb_b = 1'b1;
        @(negedge clk); bus_rst_pin = 1'b1;
        repeat (8) @(negedge clk);
        chk("R8 one-cycle reset pulse", brst_cnt, b0 + 1);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        ram_rdata = 8'h3C;
        acc(1'b1, 1'b1, 1'b1, 8'h00, sd, so);
        chk("R8 holder cleared", sd, 8'h00);
        hm = 8'h3C;
      end
      for (int i = 0; i < 6; i++) begin
        logic [7:0] w, r, st, c;
        w  = 8'(i * 53 + s * 29 + 7);
        r  = 8'(i * 91 + s * 17 + 200);
        st = 8'(i * 13 + s * 101 + 1);
        c  = 8'(i * 71 + s * 5 + 33);
        // data write
        n0 = op_cnt; w0 = we_cnt;
        acc(s[0], 1'b1, 1'b0, w, sd, so);
        chk("R2 write single op", op_cnt, n0 + 1);
        chk("R1 R2 write kind", last_kind, 2'b01);
        chk("R2 write op_data", last_data, w);
        chk("R4 ram_we pulse", we_cnt, w0 + 1);
        chk("R4 ram_wdata", last_wd, w);
        chk("R7 no drive in write", so, 0);
        hm = w;
        // data read: stale holder
        ram_rdata = r; n0 = op_cnt;
        acc(s[0], 1'b1, 1'b1, 8'h00, sd, so);
        chk("R3 read returns holder", sd, hm);
        chk("R7 drive in read", so, 1);
        chk("R1 R2 read kind", last_kind, 2'b00);
        chk("R2 read single op", op_cnt, n0 + 1);
        hm = r;
        // status read
        status_in = st; w0 = we_cnt;
        acc(s[0], 1'b0, 1'b1, 8'h00, sd, so);
        chk("R5 status byte", sd, st);
        chk("R2 status kind", last_kind, 2'b10);
        // command write
        acc(s[0], 1'b0, 1'b0, c, sd, so);
        chk("R2 command kind", last_kind, 2'b11);
        chk("R2 command data", last_data, c);
        chk("R5 no ram_we", we_cnt, w0);
        // holder untouched by status/command
        ram_rdata = ~r;
        acc(s[0], 1'b1, 1'b1, 8'h00, sd, so);
        chk("R5 holder kept", sd, hm);
        hm = ~r;
      end
      // chip deselected: ignored
      n0 = op_cnt; w0 = we_cnt;
      cs_n = 1'b1;
      acc(s[0], 1'b1, 1'b0, 8'hA5, sd, so);
      acc(s[0], 1'b1, 1'b1, 8'h00, sd, so);
      chk("R6 no drive when deselected", so, 0);
      chk("R6 no op when deselected", op_cnt, n0);
      chk("R6 no we when deselected", we_cnt, w0);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      acc(s[0], 1'b1, 1'b1, 8'h00, sd, so);
      chk("R6 holder unchanged", sd, hm);
      hm = ram_rdata;
    end
    chk("R7 never drove during write", oe_wr_flag, 0);
    done = 1;
    finish_run();
  end
endmodule